// File: doc/BRIEF.md
# Fused multiply-add NaN result selector

This unit decides which NaN a fused multiply-add `(a*b)+c` delivers when its result must be a NaN. Upstream logic classifies each of the three operands as an ordinary number, a quiet NaN or a signalling NaN, and also reports whether the multiplicands form an infinity-times-zero product. From those classes, a policy select and a use-first-NaN bit, the unit names the winning source: operand a, operand b, operand c, or the canonical default NaN. It also raises the invalid flags that the infinity-times-zero product causes.

Each supported policy fixes a priority order among the operands, says whether signalling NaNs outrank quiet ones, and says how the infinity-times-zero case resolves (default NaN or operand c). Decision and flags are registered, so they appear one clock after the inputs. Silencing of the chosen NaN and the datapath itself live elsewhere.

Top module: `fma_nan_select`

## Requirements
- R1: Operand classes use the 2-bit code 0 = number, 1 = quiet NaN, 2 = signalling NaN, 3 = treated as a number. The choice output uses 0 = a, 1 = b, 2 = c, 3 = default NaN. Outputs are registered and show the decision for the inputs present at the previous rising clock edge; during reset the choice is 3 and both flags are 0.
- R2: Policy 0: with infzero set and c a quiet NaN, the choice is 3 with invalid raised. Otherwise the first signalling NaN among c, a, b wins, and failing that the first quiet NaN among c, a, b.
- R3: Policy 1: with infzero set, the choice is 3 with invalid raised. Otherwise the first signalling NaN among a, b, c wins, then the first quiet NaN among a, b, c.
- R4: Policy 2: with infzero set, the choice is 2 with invalid raised. Otherwise signalling-before-quiet priority applies in the order c, a, b.
- R5: Policy 3: with infzero set, the choice is 2 with invalid raised. Otherwise a wins if it is any NaN, else c if it is any NaN, else b.
- R6: Policy 4 with the use-first-NaN bit set: with infzero set, the choice is 2 with invalid raised. Otherwise the first NaN of either kind among a, b, c wins.
- R7: Policy 4 with the use-first-NaN bit clear: with infzero set, the choice is 2 with invalid raised. Otherwise the first NaN of either kind among c, b, a wins.
- R8: Policies 5, 6 and 7 always choose 3 and raise invalid exactly when infzero is set.
- R9: The general invalid flag and the infinity-times-zero invalid flag are always equal. Neither is raised when infzero is clear, and under policy 0 neither is raised unless c is a quiet NaN.
- R10: When no operand of the policy's order qualifies, the last operand of that order is chosen (b for orders ending in b, c for a, b, c, a for c, b, a).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_a | input | 2 | Class code of multiplicand a |
| cls_b | input | 2 | Class code of multiplicand b |
| cls_c | input | 2 | Class code of addend c |
| inf_times_zero | input | 1 | One multiplicand is infinite and the other is zero |
| policy | input | 3 | Propagation policy select |
| first_nan_mode | input | 1 | Use-first-NaN bit for policy 4 |
| pick | output | 2 | Chosen source: a, b, c or default NaN |
| flag_invalid | output | 1 | Invalid operation flag |
| flag_inv_imz | output | 1 | Invalid flag caused by infinity times zero |

## Verification
The infinity-times-zero handling and the NaN priority pick can fall in the same cycle, because an infinite-times-zero product may come with NaN operands. Policy 0 is the sharp case, since its outcome depends on whether c is a quiet NaN. The sweep sets infzero together with every combination of operand classes under every policy and both mode bits. Each cycle's choice and both flags are compared with an arithmetic model of the policy's order and its infinity-times-zero rule.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    localparam int unsigned CLS_W = 2;
    localparam int unsigned PICK_W = 2;
    localparam int unsigned POL_W = 3;
    localparam int unsigned N_OPND = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NUM  = 2'd0,
        CLS_QNAN = 2'd1,
        CLS_SNAN = 2'd2,
        CLS_RSV  = 2'd3
    } opnd_cls_e;

    typedef enum logic [PICK_W-1:0] {
        PICK_A    = 2'd0,
        PICK_B    = 2'd1,
        PICK_C    = 2'd2,
        PICK_DFLT = 2'd3
    } pick_e;

    typedef enum logic [POL_W-1:0] {
        POL_C_SIG   = 3'd0,
        POL_LEGACY  = 3'd1,
        POL_C_2008  = 3'd2,
        POL_ANY_ACB = 3'd3,
        POL_SELECT  = 3'd4,
        POL_DFLT    = 3'd5
    } policy_e;

    typedef struct packed {
        logic [PICK_W-1:0] pick;
        logic              invalid;
        logic              inv_imz;
    } sel_out_s;

    function automatic logic cls_is_snan(input logic [CLS_W-1:0] c);
        return c == CLS_SNAN;
    endfunction

    function automatic logic cls_is_qnan(input logic [CLS_W-1:0] c);
        return c == CLS_QNAN;
    endfunction

    function automatic logic cls_is_nan(input logic [CLS_W-1:0] c);
        return (c == CLS_SNAN) || (c == CLS_QNAN);
    endfunction

endpackage

// File: rtl/nan_order_pick.sv
module nan_order_pick
    import fma_nan_pkg::*;
#(
    parameter int unsigned FIRST   = 0,
    parameter int unsigned MID     = 1,
    parameter int unsigned LAST    = 2,
    parameter bit          ANY_NAN = 1'b0
) (
    input  logic [CLS_W-1:0]  cls_a,
    input  logic [CLS_W-1:0]  cls_b,
    input  logic [CLS_W-1:0]  cls_c,
    output logic [PICK_W-1:0] sel
);

    localparam int unsigned ORDER [N_OPND] = '{FIRST, MID, LAST};

    logic [CLS_W-1:0] cls_by_idx [N_OPND];

    assign cls_by_idx[0] = cls_a;
    assign cls_by_idx[1] = cls_b;
    assign cls_by_idx[2] = cls_c;

    generate
        if (ANY_NAN) begin : g_any
            // walk backwards so the earliest qualifying operand wins
            always_comb begin
                sel = PICK_W'(LAST);
                for (int k = N_OPND - 1; k >= 0; k--) begin
                    if (cls_is_nan(cls_by_idx[ORDER[k]])) begin
                        sel = PICK_W'(ORDER[k]);
                    end
                end
            end
        end else begin : g_sig_first
            // quiet pass first, then the signalling pass overrides it
            always_comb begin
                sel = PICK_W'(LAST);
                for (int k = N_OPND - 1; k >= 0; k--) begin
                    if (cls_is_qnan(cls_by_idx[ORDER[k]])) begin
                        sel = PICK_W'(ORDER[k]);
                    end
                end
                for (int k = N_OPND - 1; k >= 0; k--) begin
                    if (cls_is_snan(cls_by_idx[ORDER[k]])) begin
                        sel = PICK_W'(ORDER[k]);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLS_W-1:0]  cls_a,
    input  logic [CLS_W-1:0]  cls_b,
    input  logic [CLS_W-1:0]  cls_c,
    input  logic              inf_times_zero,
    input  logic [POL_W-1:0]  policy,
    input  logic              first_nan_mode,
    output logic [PICK_W-1:0] pick,
    output logic              flag_invalid,
    output logic              flag_inv_imz
);

    localparam sel_out_s RESET_OUT = '{pick: PICK_DFLT, invalid: 1'b0, inv_imz: 1'b0};

    logic [PICK_W-1:0] sel_cab_sig;
    logic [PICK_W-1:0] sel_abc_sig;
    logic [PICK_W-1:0] sel_acb_any;
    logic [PICK_W-1:0] sel_abc_any;
    logic [PICK_W-1:0] sel_cba_any;

    nan_order_pick #(.FIRST(2), .MID(0), .LAST(1), .ANY_NAN(1'b0)) u_cab_sig (
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c), .sel(sel_cab_sig));
    nan_order_pick #(.FIRST(0), .MID(1), .LAST(2), .ANY_NAN(1'b0)) u_abc_sig (
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c), .sel(sel_abc_sig));
    nan_order_pick #(.FIRST(0), .MID(2), .LAST(1), .ANY_NAN(1'b1)) u_acb_any (
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c), .sel(sel_acb_any));
    nan_order_pick #(.FIRST(0), .MID(1), .LAST(2), .ANY_NAN(1'b1)) u_abc_any (
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c), .sel(sel_abc_any));
    nan_order_pick #(.FIRST(2), .MID(1), .LAST(0), .ANY_NAN(1'b1)) u_cba_any (
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c), .sel(sel_cba_any));

    sel_out_s out_d;
    sel_out_s out_q;

    always_comb begin
        out_d = RESET_OUT;
        case (policy)
            POL_C_SIG: begin
                if (inf_times_zero && cls_is_qnan(cls_c)) begin
                    out_d.invalid = 1'b1;
                    out_d.pick    = PICK_DFLT;
                end else begin
                    out_d.pick = sel_cab_sig;
                end
            end
            POL_LEGACY: begin
                out_d.invalid = inf_times_zero;
                out_d.pick    = inf_times_zero ? PICK_DFLT : sel_abc_sig;
            end
            POL_C_2008: begin
                out_d.invalid = inf_times_zero;
                out_d.pick    = inf_times_zero ? PICK_C : sel_cab_sig;
            end
            POL_ANY_ACB: begin
                out_d.invalid = inf_times_zero;
                out_d.pick    = inf_times_zero ? PICK_C : sel_acb_any;
            end
            POL_SELECT: begin
                out_d.invalid = inf_times_zero;
                if (inf_times_zero) begin
                    out_d.pick = PICK_C;
                end else begin
                    out_d.pick = first_nan_mode ? sel_abc_any : sel_cba_any;
                end
            end
            default: begin
                out_d.invalid = inf_times_zero;
                out_d.pick    = PICK_DFLT;
            end
        endcase
        out_d.inv_imz = out_d.invalid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= RESET_OUT;
        end else begin
            out_q <= out_d;
        end
    end

    assign pick         = out_q.pick;
    assign flag_invalid = out_q.invalid;
    assign flag_inv_imz = out_q.inv_imz;

    // R9
    no_inv_without_imz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inf_times_zero |=> (!flag_invalid && !flag_inv_imz));

    // R8
    dflt_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy >= POL_DFLT) |=> (pick == PICK_DFLT));

    // R3
    legacy_imz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_LEGACY && inf_times_zero) |=> (pick == PICK_DFLT && flag_invalid));

    // R4
    c2008_imz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_C_2008 && inf_times_zero) |=> (pick == PICK_C && flag_inv_imz));

    // R5
    acb_a_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_ANY_ACB && !inf_times_zero && cls_is_nan(cls_a)) |=> (pick == PICK_A));

    // R2
    csig_snan_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_C_SIG && cls_is_snan(cls_c)) |=> (pick == PICK_C && !flag_invalid));

    // R6
    sel_first_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_SELECT && first_nan_mode && !inf_times_zero && cls_is_nan(cls_a))
        |=> (pick == PICK_A));

    // R7
    sel_last_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_SELECT && !first_nan_mode && !inf_times_zero && cls_is_nan(cls_c))
        |=> (pick == PICK_C));

endmodule

// File: tb/test_fma_nan_select.sv
module test_fma_nan_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cls_a = 2'd0;
    logic [1:0] cls_b = 2'd0;
    logic [1:0] cls_c = 2'd0;
    logic       inf_times_zero = 1'b0;
    logic [2:0] policy = 3'd0;
    logic       first_nan_mode = 1'b0;
    logic [1:0] pick;
    logic       flag_invalid;
    logic       flag_inv_imz;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    fma_nan_select i_fma_nan_select (
        .clk(clk), .rst_n(rst_n),
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
        .inf_times_zero(inf_times_zero), .policy(policy),
        .first_nan_mode(first_nan_mode),
        .pick(pick), .flag_invalid(flag_invalid), .flag_inv_imz(flag_inv_imz));

    function automatic int cls_of(input int idx, input int ca, input int cb, input int cc);
        return (idx == 0) ? ca : ((idx == 1) ? cb : cc);
    endfunction

    // scan an order; sig_first = signalling NaNs outrank quiet ones
    function automatic int scan(input int o0, input int o1, input int o2, input bit sig_first,
                                input int ca, input int cb, input int cc);
        int ord [3];
        ord = '{o0, o1, o2};
        if (sig_first) begin
            for (int i = 0; i < 3; i++) if (cls_of(ord[i], ca, cb, cc) == 2) return ord[i];
            for (int i = 0; i < 3; i++) if (cls_of(ord[i], ca, cb, cc) == 1) return ord[i];
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (cls_of(ord[i], ca, cb, cc) == 1 || cls_of(ord[i], ca, cb, cc) == 2) return ord[i];
            end
        end
        return o2;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d c=%0d iz=%0d pol=%0d fm=%0d)",
                     tag, got, exp, cls_a, cls_b, cls_c, inf_times_zero, policy, first_nan_mode);
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int exp_pick;
        int exp_inv;
        int ca, cb, cc;
        string tag;
        // R1 reset state, with inputs that would otherwise produce a different value
        cls_a = 2'd2; inf_times_zero = 1'b1; policy = 3'd2;
        repeat (3) @(negedge clk);
        check("R1 reset pick", int'(pick), 3);
        check("R1 reset invalid", int'(flag_invalid), 0);
        check("R1 reset imz", int'(flag_inv_imz), 0);
        rst_n = 1'b1;
        for (int pol = 0; pol < 8; pol++) begin
            for (int fm = 0; fm < 2; fm++) begin
                for (int iz = 0; iz < 2; iz++) begin
                    for (int code = 0; code < 64; code++) begin
                        ca = code % 4;
                        cb = (code / 4) % 4;
                        cc = code / 16;
                        if (iz == 0 && !(ca inside {1, 2}) && !(cb inside {1, 2}) && !(cc inside {1, 2}))
                            continue;
                        cls_a = 2'(ca); cls_b = 2'(cb); cls_c = 2'(cc);
                        inf_times_zero = iz[0]; policy = 3'(pol); first_nan_mode = fm[0];
                        exp_inv = iz;
                        case (pol)
                            0: begin
                                tag = "R2";
                                exp_inv = (iz == 1 && cc == 1) ? 1 : 0;
                                exp_pick = exp_inv ? 3 : scan(2, 0, 1, 1'b1, ca, cb, cc);
                            end
                            1: begin tag = "R3"; exp_pick = iz ? 3 : scan(0, 1, 2, 1'b1, ca, cb, cc); end
                            2: begin tag = "R4"; exp_pick = iz ? 2 : scan(2, 0, 1, 1'b1, ca, cb, cc); end
                            3: begin tag = "R5"; exp_pick = iz ? 2 : scan(0, 2, 1, 1'b0, ca, cb, cc); end
                            4: begin
                                if (fm == 1) begin
                                    tag = "R6"; exp_pick = iz ? 2 : scan(0, 1, 2, 1'b0, ca, cb, cc);
                                end else begin
                                    tag = "R7"; exp_pick = iz ? 2 : scan(2, 1, 0, 1'b0, ca, cb, cc);
                                end
                            end
                            default: begin tag = "R8"; exp_pick = 3; end
                        endcase
                        if (pol == 0 && iz == 1 && exp_inv == 0 &&
                            !(ca inside {1, 2}) && !(cb inside {1, 2}) && !(cc inside {1, 2}))
                            tag = "R10";
                        @(negedge clk);
                        check({tag, " pick"}, int'(pick), exp_pick);
                        check("R9 invalid", int'(flag_invalid), exp_inv);
                        check("R9 imz", int'(flag_inv_imz), exp_inv);
                    end
                end
            end
        end
        // R1 latency: a change is visible only after the next rising edge
        cls_a = 2'd1; cls_b = 2'd0; cls_c = 2'd0; inf_times_zero = 1'b0; policy = 3'd1;
        @(negedge clk);
        check("R1 settle", int'(pick), 0);
        @(posedge clk);
        #1;
        cls_a = 2'd0; cls_b = 2'd2;
        #2;
        check("R1 held", int'(pick), 0);
        @(negedge clk);
        check("R1 next", int'(pick), 0);
        @(negedge clk);
        check("R1 updated", int'(pick), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule